// File: doc/BRIEF.md
# DRAM ZQ Calibration Sequencer

This block decides when the memory controller sends ZQ calibration commands to up to four DRAM ranks. Periodic short calibrations run at an interval chosen by a 3-bit code. Each interval is cut into one slot per rank, and every slot calibrates exactly one rank, so two periodic commands never overlap. Software can start a short or long calibration of all ranks through a self-clearing start bit. A self-refresh exit pulse starts a long calibration sequence. A 2-bit field selects whether that sequence is sent to all ranks at once, to each rank in turn, or not at all.

The block has three inputs: a one-millisecond tick, the self-refresh exit pulse and a small configuration register. It sends commands downstream through a valid/acknowledge handshake that carries a rank index, an all-ranks flag and a long/short flag. After each accepted command it waits for a done pulse before it issues the next one. Command timing belongs to the downstream logic.

Top module: `zq_cal_sequencer`

## Requirements
- R1: After reset the interval code reads 3, the post-exit mode reads 1, the type bit and the start bit read 0, and `req_valid` is low.
- R2: A configuration write with the start bit at 1 sets `cfg_start`. The bit stays 1 until the software calibration's `cmd_done`, then clears. A write with the start bit at 0 while it is set leaves it at 1.
- R3: A software calibration issues exactly one request with `req_all`=1 and `req_long` equal to the type bit (0 = short, 1 = long).
- R4: The interval code maps to milliseconds as 1→62000, 2→31, 3→63 and 4→126. Periodic requests are spaced floor(interval/4) ticks apart: 15 for code 3, 7 for code 2 and 31 for code 4.
- R5: Each periodic request is short (`req_long`=0) and targets one rank (`req_all`=0). The rank index goes 0,1,2,3 and then wraps back to 0.
- R6: A change of interval code while the block runs takes effect at the next slot. From then on the spacing follows the new code.
- R7: Code 0 and the reserved codes 5, 6 and 7 produce no periodic requests.
- R8: With post-exit mode 0, a self-refresh exit pulse produces one request with `req_all`=1 and `req_long`=1.
- R9: With post-exit mode 1, a self-refresh exit pulse produces one long single-rank request per rank, ranks 0 to 3 in order. Each request waits for the previous `cmd_done`.
- R10: Post-exit modes 2 and 3 produce no request on a self-refresh exit.
- R11: When several jobs are waiting in the idle state, a post-exit sequence is served before a periodic slot, and a periodic slot before a software start. A job that arrives while another runs is kept until the sequencer is idle.
- R12: `req_valid` stays high with rank, all and long fields unchanged until `req_ack`. No new request appears before `cmd_done` of the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sr_exit | input | 1 | One-cycle pulse on self-refresh exit |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_ivl | input | 3 | Interval code to write |
| cfg_wr_srx | input | 2 | Post-exit mode to write |
| cfg_wr_long | input | 1 | Type bit to write (1 = long) |
| cfg_wr_start | input | 1 | Start bit to write (only 1 has effect) |
| cfg_ivl | output | 3 | Current interval code |
| cfg_srx | output | 2 | Current post-exit mode |
| cfg_long | output | 1 | Current type bit |
| cfg_start | output | 1 | Start bit, high while a software calibration is pending or running |
| req_valid | output | 1 | Command request |
| req_ack | input | 1 | Request accepted |
| req_rank | output | 2 | Target rank when `req_all` is 0 |
| req_all | output | 1 | Command goes to all ranks at once |
| req_long | output | 1 | 1 = long calibration, 0 = short |
| cmd_done | input | 1 | Accepted command has completed |

## Verification
The hardest case to reach is a collision of jobs. A software start, a self-refresh exit and a periodic slot must all be waiting at once for the priority order to show. The bench gets there by withholding the acknowledge while the software request is outstanding. It pulses the exit input during that stall and switches on a short interval with ticks running until a slot fires. Then it releases the handshake and reads the order of the requests that follow. The same stall is used to show that the outstanding request holds its fields steady and that a start-bit write of 0 is ignored.

// File: rtl/zqs_pkg.sv
package zqs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_t;

  typedef enum logic [1:0] {
    JOB_NONE = 2'd0,
    JOB_PER  = 2'd1,
    JOB_SRX  = 2'd2,
    JOB_SW   = 2'd3
  } job_t;

  // post self-refresh exit modes
  localparam logic [1:0] SRX_PARALLEL = 2'd0;
  localparam logic [1:0] SRX_SERIAL   = 2'd1;

  // interval code -> milliseconds; 0 and reserved codes mean disabled
  function automatic int unsigned ivl_ms(input logic [2:0] code,
                                         input int unsigned ms_sim,
                                         input int unsigned ms_c2,
                                         input int unsigned ms_c3,
                                         input int unsigned ms_c4);
    case (code)
      3'd1:    return ms_sim;
      3'd2:    return ms_c2;
      3'd3:    return ms_c3;
      3'd4:    return ms_c4;
      default: return 0;
    endcase
  endfunction

  // ticks between consecutive per-rank slots
  function automatic int unsigned slot_ticks(input logic [2:0] code,
                                             input int unsigned ms_sim,
                                             input int unsigned ms_c2,
                                             input int unsigned ms_c3,
                                             input int unsigned ms_c4,
                                             input int unsigned nranks);
    return ivl_ms(code, ms_sim, ms_c2, ms_c3, ms_c4) / nranks;
  endfunction

  function automatic logic srx_runs(input logic [1:0] mode);
    return (mode == SRX_PARALLEL) || (mode == SRX_SERIAL);
  endfunction

endpackage

// File: rtl/zqs_cfg_reg.sv
module zqs_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_wr_ivl,
  input  logic [1:0] cfg_wr_srx,
  input  logic       cfg_wr_long,
  input  logic       cfg_wr_start,
  input  logic       sw_done,
  output logic [2:0] cfg_ivl,
  output logic [1:0] cfg_srx,
  output logic       cfg_long,
  output logic       cfg_start
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_ivl   <= 3'd3;
      cfg_srx   <= 2'd1;
      cfg_long  <= 1'b0;
      cfg_start <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_ivl  <= cfg_wr_ivl;
        cfg_srx  <= cfg_wr_srx;
        cfg_long <= cfg_wr_long;
      end
      if (cfg_wr && cfg_wr_start) cfg_start <= 1'b1;
      else if (sw_done)           cfg_start <= 1'b0;
    end
  end

  // start bit only falls through completion
  p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_start && !sw_done) |=> cfg_start);

  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_done && !(cfg_wr && cfg_wr_start)) |=> !cfg_start);

endmodule

// File: rtl/zqs_slot_timer.sv
module zqs_slot_timer #(
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned MS_SIM    = 62000,
  parameter int unsigned MS_CODE2  = 31,
  parameter int unsigned MS_CODE3  = 63,
  parameter int unsigned MS_CODE4  = 126,
  localparam int unsigned RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int unsigned CW = $clog2(MS_SIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic [2:0]    ivl_code,
  output logic          slot_evt,
  output logic [RW-1:0] slot_rank
);
  import zqs_pkg::*;

  localparam logic [RW-1:0] LAST_RANK = RW'(NUM_RANKS - 1);

  logic [CW-1:0] slot_len;
  logic [CW-1:0] cnt;

  assign slot_len = CW'(slot_ticks(ivl_code, MS_SIM, MS_CODE2, MS_CODE3,
                                   MS_CODE4, NUM_RANKS));

  // comparing with >= lets a shortened interval fire on the next tick
  assign slot_evt = ms_tick && (slot_len != '0) && (cnt >= slot_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (slot_len == '0)   cnt <= '0;
    else if (slot_evt)         cnt <= '0;
    else if (ms_tick)          cnt <= cnt + 1'b1;
  end

  generate
    if (NUM_RANKS == 1) begin : g_one_rank
      assign slot_rank = '0;
    end else begin : g_rank_rr
      logic [RW-1:0] rr;
      always_ff @(posedge clk) begin
        if (!rst_n)        rr <= '0;
        else if (slot_evt) rr <= (rr == LAST_RANK) ? '0 : rr + 1'b1;
      end
      assign slot_rank = rr;
    end
  endgenerate

  // independent tick count between events, for the spacing check
  logic [CW-1:0] gap;
  logic          gap_seen;
  logic          code_chg;
  logic [2:0]    code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap      <= '0;
      gap_seen <= 1'b0;
      code_chg <= 1'b0;
      code_q   <= 3'd0;
    end else begin
      code_q <= ivl_code;
      if (slot_evt) begin
        gap      <= '0;
        gap_seen <= 1'b1;
        code_chg <= 1'b0;
      end else begin
        if (ms_tick && gap != '1) gap <= gap + 1'b1;
        if (code_q != ivl_code)   code_chg <= 1'b1;
      end
    end
  end

  p_slot_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_evt && gap_seen && !code_chg && code_q == ivl_code)
      |-> (gap + 1'b1 == slot_len));

  p_no_slot_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_code == 3'd0 || ivl_code >= 3'd5) |-> !slot_evt);

endmodule

// File: rtl/zqs_cmd_fsm.sv
module zqs_cmd_fsm #(
  parameter int unsigned NUM_RANKS = 4,
  localparam int unsigned RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_exit,
  input  logic [1:0]    srx_mode,
  input  logic          slot_evt,
  input  logic [RW-1:0] slot_rank,
  input  logic          sw_start,
  input  logic          sw_long,
  output logic          sw_done,
  output logic          req_valid,
  input  logic          req_ack,
  output logic [RW-1:0] req_rank,
  output logic          req_all,
  output logic          req_long,
  input  logic          cmd_done
);
  import zqs_pkg::*;

  localparam logic [RW-1:0] LAST_RANK = RW'(NUM_RANKS - 1);

  seq_st_t       st;
  job_t          job;
  logic [RW-1:0] cur_rank;
  logic          cur_all;
  logic          cur_long;
  logic          srx_pend, srx_pend_ser, srx_ser;
  logic          per_pend;
  logic [RW-1:0] per_rank;

  logic take_srx, take_per, take_sw, more_ranks, job_fin;

  assign take_srx   = (st == ST_IDLE) && srx_pend;
  assign take_per   = (st == ST_IDLE) && !srx_pend && per_pend;
  assign take_sw    = (st == ST_IDLE) && !srx_pend && !per_pend && sw_start;
  assign more_ranks = (job == JOB_SRX) && srx_ser && (cur_rank != LAST_RANK);
  assign job_fin    = (st == ST_WAIT) && cmd_done && !more_ranks;
  assign sw_done    = job_fin && (job == JOB_SW);

  // pending requests; a new arrival wins over the clear of the one taken
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srx_pend     <= 1'b0;
      srx_pend_ser <= 1'b0;
      per_pend     <= 1'b0;
      per_rank     <= '0;
    end else begin
      if (sr_exit && srx_runs(srx_mode)) begin
        srx_pend     <= 1'b1;
        srx_pend_ser <= (srx_mode == SRX_SERIAL);
      end else if (take_srx) begin
        srx_pend <= 1'b0;
      end
      if (slot_evt) begin
        per_pend <= 1'b1;
        per_rank <= slot_rank;
      end else if (take_per) begin
        per_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      job      <= JOB_NONE;
      cur_rank <= '0;
      cur_all  <= 1'b0;
      cur_long <= 1'b0;
      srx_ser  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (take_srx) begin
            st       <= ST_REQ;
            job      <= JOB_SRX;
            srx_ser  <= srx_pend_ser;
            cur_rank <= '0;
            cur_all  <= !srx_pend_ser;
            cur_long <= 1'b1;
          end else if (take_per) begin
            st       <= ST_REQ;
            job      <= JOB_PER;
            cur_rank <= per_rank;
            cur_all  <= 1'b0;
            cur_long <= 1'b0;
          end else if (take_sw) begin
            st       <= ST_REQ;
            job      <= JOB_SW;
            cur_rank <= '0;
            cur_all  <= 1'b1;
            cur_long <= sw_long;
          end
        end
        ST_REQ: if (req_ack) st <= ST_WAIT;
        ST_WAIT: begin
          if (cmd_done) begin
            if (more_ranks) begin
              st       <= ST_REQ;
              cur_rank <= cur_rank + 1'b1;
            end else begin
              st  <= ST_IDLE;
              job <= JOB_NONE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st == ST_REQ);
  assign req_rank  = cur_rank;
  assign req_all   = cur_all;
  assign req_long  = cur_long;

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=>
      (req_valid && $stable(req_rank) && $stable(req_all) && $stable(req_long)));

  p_srx_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && srx_pend) |=> (req_valid && req_long));

  p_serial_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && cmd_done && more_ranks) |=>
      (req_valid && req_rank == $past(req_rank) + 1'b1 && !req_all));

  p_no_req_in_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !cmd_done) |=> !req_valid);

endmodule

// File: rtl/zq_cal_sequencer.sv
module zq_cal_sequencer #(
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned MS_SIM    = 62000,
  parameter int unsigned MS_CODE2  = 31,
  parameter int unsigned MS_CODE3  = 63,
  parameter int unsigned MS_CODE4  = 126,
  localparam int unsigned RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          sr_exit,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_wr_ivl,
  input  logic [1:0]    cfg_wr_srx,
  input  logic          cfg_wr_long,
  input  logic          cfg_wr_start,
  output logic [2:0]    cfg_ivl,
  output logic [1:0]    cfg_srx,
  output logic          cfg_long,
  output logic          cfg_start,
  output logic          req_valid,
  input  logic          req_ack,
  output logic [RW-1:0] req_rank,
  output logic          req_all,
  output logic          req_long,
  input  logic          cmd_done
);

  logic          sw_done;
  logic          slot_evt;
  logic [RW-1:0] slot_rank;

  zqs_cfg_reg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_wr_ivl   (cfg_wr_ivl),
    .cfg_wr_srx   (cfg_wr_srx),
    .cfg_wr_long  (cfg_wr_long),
    .cfg_wr_start (cfg_wr_start),
    .sw_done      (sw_done),
    .cfg_ivl      (cfg_ivl),
    .cfg_srx      (cfg_srx),
    .cfg_long     (cfg_long),
    .cfg_start    (cfg_start)
  );

  zqs_slot_timer #(
    .NUM_RANKS (NUM_RANKS),
    .MS_SIM    (MS_SIM),
    .MS_CODE2  (MS_CODE2),
    .MS_CODE3  (MS_CODE3),
    .MS_CODE4  (MS_CODE4)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .ivl_code  (cfg_ivl),
    .slot_evt  (slot_evt),
    .slot_rank (slot_rank)
  );

  zqs_cmd_fsm #(
    .NUM_RANKS (NUM_RANKS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_exit   (sr_exit),
    .srx_mode  (cfg_srx),
    .slot_evt  (slot_evt),
    .slot_rank (slot_rank),
    .sw_start  (cfg_start),
    .sw_long   (cfg_long),
    .sw_done   (sw_done),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_rank  (req_rank),
    .req_all   (req_all),
    .req_long  (req_long),
    .cmd_done  (cmd_done)
  );

endmodule

// File: tb/zq_cal_sequencer_bench.sv
`timescale 1ns/1ps
module zq_cal_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       sr_exit = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_wr_ivl = 3'd0;
  logic [1:0] cfg_wr_srx = 2'd0;
  logic       cfg_wr_long = 1'b0;
  logic       cfg_wr_start = 1'b0;
  logic [2:0] cfg_ivl;
  logic [1:0] cfg_srx;
  logic       cfg_long, cfg_start;
  logic       req_valid, req_all, req_long;
  logic [1:0] req_rank;
  logic       req_ack = 1'b0;
  logic       cmd_done = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  zq_cal_sequencer u_zq_cal_sequencer (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sr_exit(sr_exit),
    .cfg_wr(cfg_wr), .cfg_wr_ivl(cfg_wr_ivl), .cfg_wr_srx(cfg_wr_srx),
    .cfg_wr_long(cfg_wr_long), .cfg_wr_start(cfg_wr_start),
    .cfg_ivl(cfg_ivl), .cfg_srx(cfg_srx), .cfg_long(cfg_long),
    .cfg_start(cfg_start), .req_valid(req_valid), .req_ack(req_ack),
    .req_rank(req_rank), .req_all(req_all), .req_long(req_long),
    .cmd_done(cmd_done)
  );

  // request log filled by the responder
  int log_n = 0;
  int log_rank [16];
  int log_all  [16];
  int log_long [16];
  int log_tick [16];
  int tick_cnt = 0;
  bit tick_en = 0;
  bit resp_en = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // millisecond tick every 8 cycles while enabled
  initial begin
    forever begin
      @(negedge clk);
      if (tick_en) begin
        repeat (6) @(negedge clk);
        ms_tick = 1'b1;
        tick_cnt++;
        @(negedge clk);
        ms_tick = 1'b0;
      end
    end
  end

  // downstream: acknowledge, then done three cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (resp_en && req_valid) begin
        if (log_n < 16) begin
          log_rank[log_n] = int'(req_rank);
          log_all[log_n]  = int'(req_all);
          log_long[log_n] = int'(req_long);
          log_tick[log_n] = tick_cnt;
        end
        log_n++;
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        repeat (3) @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
      end
    end
  end

  task automatic write_cfg(input logic [2:0] ivl, input logic [1:0] srx,
                           input logic lng, input logic start);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wr_ivl = ivl; cfg_wr_srx = srx;
    cfg_wr_long = lng; cfg_wr_start = start;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wr_start = 1'b0;
  endtask

  task automatic pulse_srx();
    @(negedge clk);
    sr_exit = 1'b1;
    @(negedge clk);
    sr_exit = 1'b0;
  endtask

  task automatic wait_log(input int n, input int max_cyc);
    for (int i = 0; i < max_cyc && log_n < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cfg_ivl == 3'd3, "R1 ivl code", int'(cfg_ivl), 3);
    chk(cfg_srx == 2'd1, "R1 srx mode", int'(cfg_srx), 1);
    chk(!cfg_long && !cfg_start, "R1 long/start", int'({cfg_long, cfg_start}), 0);
    chk(!req_valid, "R1 req_valid", int'(req_valid), 0);
  endtask

  task automatic t_software();
    log_n = 0;
    write_cfg(3'd3, 2'd1, 1'b1, 1'b1);
    chk(cfg_start, "R2 start set", int'(cfg_start), 1);
    wait_log(1, 50);
    repeat (12) @(negedge clk);
    chk(log_n == 1, "R3 one sw request", log_n, 1);
    chk(log_all[0] == 1 && log_long[0] == 1, "R3 long broadcast",
        log_all[0] * 2 + log_long[0], 3);
    chk(!cfg_start, "R2 start cleared", int'(cfg_start), 0);
    log_n = 0;
    write_cfg(3'd3, 2'd1, 1'b0, 1'b1);
    wait_log(1, 50);
    repeat (12) @(negedge clk);
    chk(log_n == 1 && log_all[0] == 1 && log_long[0] == 0, "R3 short broadcast",
        log_long[0], 0);
  endtask

  task automatic t_srx();
    log_n = 0;
    write_cfg(3'd3, 2'd0, 1'b0, 1'b0);
    pulse_srx();
    repeat (60) @(negedge clk);
    chk(log_n == 1, "R8 parallel count", log_n, 1);
    chk(log_all[0] == 1 && log_long[0] == 1, "R8 parallel long all",
        log_all[0] * 2 + log_long[0], 3);
    log_n = 0;
    write_cfg(3'd3, 2'd1, 1'b0, 1'b0);
    pulse_srx();
    repeat (100) @(negedge clk);
    chk(log_n == 4, "R9 serial count", log_n, 4);
    for (int i = 0; i < 4; i++)
      chk(log_rank[i] == i && log_all[i] == 0 && log_long[i] == 1,
          "R9 serial rank", log_rank[i], i);
    for (int m = 2; m < 4; m++) begin
      log_n = 0;
      write_cfg(3'd3, 2'(m), 1'b0, 1'b0);
      pulse_srx();
      repeat (40) @(negedge clk);
      chk(log_n == 0, "R10 no post-exit cal", log_n, 0);
    end
  endtask

  task automatic t_periodic();
    log_n = 0;
    tick_cnt = 0;
    write_cfg(3'd3, 2'd2, 1'b0, 1'b0);
    tick_en = 1;
    wait_log(5, 5000);
    chk(log_n == 5, "R5 periodic count", log_n, 5);
    chk(log_tick[0] == 15, "R4 first slot code 3", log_tick[0], 15);
    for (int i = 0; i < 5; i++) begin
      chk(log_rank[i] == (i % 4), "R5 rank order", log_rank[i], i % 4);
      chk(log_all[i] == 0 && log_long[i] == 0, "R5 short single rank",
          log_all[i] * 2 + log_long[i], 0);
    end
    for (int i = 1; i < 5; i++)
      chk(log_tick[i] - log_tick[i-1] == 15, "R4 spacing code 3",
          log_tick[i] - log_tick[i-1], 15);
    // change on the fly to a shorter interval
    log_n = 0;
    write_cfg(3'd2, 2'd2, 1'b0, 1'b0);
    wait_log(3, 3000);
    chk(log_tick[0] <= tick_cnt && log_n == 3, "R6 new code running", log_n, 3);
    chk(log_tick[2] - log_tick[1] == 7, "R6 spacing after change",
        log_tick[2] - log_tick[1], 7);
    log_n = 0;
    write_cfg(3'd4, 2'd2, 1'b0, 1'b0);
    wait_log(3, 6000);
    chk(log_tick[2] - log_tick[1] == 31, "R4 spacing code 4",
        log_tick[2] - log_tick[1], 31);
    // disabled and reserved codes
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c >= 5) begin
        write_cfg(3'(c), 2'd2, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        log_n = 0;
        repeat (8 * 40) @(negedge clk);
        chk(log_n == 0, "R7 no periodic request", log_n, 0);
      end
    end
    tick_en = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_priority();
    logic [1:0] r0;
    logic       l0, a0;
    write_cfg(3'd0, 2'd0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    resp_en = 0;
    log_n = 0;
    write_cfg(3'd0, 2'd0, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk(req_valid, "R12 sw request up", int'(req_valid), 1);
    r0 = req_rank; l0 = req_long; a0 = req_all;
    repeat (10) @(negedge clk);
    chk(req_valid && req_rank == r0 && req_long == l0 && req_all == a0,
        "R12 request held stable", int'(req_valid), 1);
    write_cfg(3'd0, 2'd0, 1'b0, 1'b0);
    chk(cfg_start, "R2 zero write ignored", int'(cfg_start), 1);
    pulse_srx();
    write_cfg(3'd2, 2'd0, 1'b0, 1'b0);
    tick_en = 1;
    repeat (8 * 9) @(negedge clk);
    tick_en = 0;
    write_cfg(3'd0, 2'd0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk(req_valid && req_all == a0 && req_long == l0, "R12 still waiting",
        int'(req_valid), 1);
    resp_en = 1;
    repeat (120) @(negedge clk);
    chk(log_n == 3, "R11 job count", log_n, 3);
    chk(log_all[0] == 1 && log_long[0] == 0, "R11 sw first (running)",
        log_long[0], 0);
    chk(log_all[1] == 1 && log_long[1] == 1, "R11 post-exit before periodic",
        log_all[1] * 2 + log_long[1], 3);
    chk(log_all[2] == 0 && log_long[2] == 0, "R11 periodic last",
        log_all[2] * 2 + log_long[2], 0);
    chk(!cfg_start, "R2 start cleared after stall", int'(cfg_start), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_software();
    t_srx();
    t_periodic();
    t_priority();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule